// File: doc/BRIEF.md
# Gated Busy-Width Conversion Reader

This block reads the result of a dual-slope converter without a digit bus. The converter signals one measurement by holding a single busy line high from the start of signal integration to the end of reference de-integration. The block measures how long that line stays high and turns the width back into the converter's reading. It also makes the converter's clock, so that the measuring counter and the converter run from the same reference.

A reference tick input is divided by `DIV` (default 4) to form the converter clock. A counter, gated by the synchronized busy line, advances twice per converter clock period. On the falling edge of busy the count is halved to get converter clocks, the fixed integration length `OFFSET` (default 10001) is taken off, and the reading goes out on a valid/ready port with an overrange flag. The counter then clears for the next measurement.

The output port follows valid/ready rules. `res_valid` rises when a measurement ends and stays high, with `res_value` and `res_ovr` held, until a cycle with `res_ready` high. The converter cannot be paused, so a measurement that ends while an older reading is still waiting replaces that reading.

Top module: `busyw_reader`

## Requirements
- R1: `conv_clk` is the reference tick divided by `DIV`. A phase count advances on each tick, and `conv_clk` is high while the phase is in the upper half of its range. `conv_clk` changes only on a clock edge where `ref_tick` is high.
- R2: The width counter advances only while the synchronized busy line is high. It advances by one on every `DIV/2`-th reference tick, which is twice per converter clock period. At all other times it holds.
- R3: The width counter saturates at its all-ones value (`CNT_W` bits, default 17) and never wraps.
- R4: `busy_in` passes through two flip-flops before edge detection. If `busy_in` is first sampled low at clock edge k, `res_valid` is high after edge k+2 and not before.
- R5: The reading is floor(count / 2) minus `OFFSET`, where count is the counter value at the falling edge.
- R6: If floor(count / 2) is below `OFFSET`, the reading is zero.
- R7: `res_ovr` is 1 exactly when the reading is greater than `RANGE` (default 20000).
- R8: While `res_valid` is high and `res_ready` is low, `res_valid`, `res_value` and `res_ovr` hold, unless a new measurement ends. `res_valid` drops after an edge that sees `res_ready` high.
- R9: The counter is zero after the falling-edge cycle, so each measurement starts counting from zero.
- R10: After reset, `res_valid`, `res_value`, `res_ovr` and `conv_clk` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle reference pulse that drives the divider |
| busy_in | input | 1 | Asynchronous busy line from the converter |
| conv_clk | output | 1 | Divided clock for the converter |
| res_valid | output | 1 | Reading available |
| res_ready | input | 1 | Consumer accepts the reading |
| res_value | output | CNT_W-1 | Offset-corrected reading |
| res_ovr | output | 1 | Reading above RANGE |

## Verification
The assertions check on every cycle that the divider output moves only on reference ticks, that the counter holds when it is idle, saturates and clears after a falling edge, and that a waiting reading stays stable and agrees with its overrange flag. The arithmetic of a reading can only be shown by the bench. So can the exact two-flop latency from busy to valid, the clamp to zero, and the fact that idle time and gaps in the reference ticks add nothing. The bench shows these with busy windows of known length, compared against a behavioural model on every clock.

// File: rtl/busyw_pkg.sv
package busyw_pkg;
  localparam int DIV_DEF    = 4;
  localparam int CNT_W_DEF  = 17;
  localparam int OFFSET_DEF = 10001;
  localparam int RANGE_DEF  = 20000;
endpackage

// File: rtl/busyw_divider.sv
module busyw_divider #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  output logic conv_clk,
  output logic cnt_tick
);
  localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF = DIV / 2;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);
  localparam logic [PH_W-1:0] PH_MID  = PH_W'(HALF - 1);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(HALF);

  logic [PH_W-1:0] ph, ph_nxt;

  always_comb begin
    ph_nxt = (ph == PH_LAST) ? '0 : ph + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= '0;
      conv_clk <= 1'b0;
    end else if (ref_tick) begin
      ph       <= ph_nxt;
      conv_clk <= (ph_nxt >= PH_HALF);
    end
  end

  // two counting ticks per converter clock period
  assign cnt_tick = ref_tick && ((ph == PH_MID) || (ph == PH_LAST));

  AST_CLK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_tick |=> $stable(conv_clk)); // R1
endmodule

// File: rtl/busyw_sync.sv
module busyw_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_in,
  output logic busy_s,
  output logic busy_fall
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= busy_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign busy_s    = sync_q;
  assign busy_fall = prev_q && !sync_q;
endmodule

// File: rtl/busyw_counter.sv
module busyw_counter #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy_s,
  input  logic             busy_fall,
  input  logic             cnt_tick,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (busy_fall) begin
      count <= '0;
    end else if (busy_s && cnt_tick && (count != '1)) begin
      count <= count + 1'b1;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_s && !busy_fall) |=> $stable(count)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((count == '1) && !busy_fall) |=> (count == '1)); // R3
  AST_CLEAR_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    busy_fall |=> (count == '0)); // R9
endmodule

// File: rtl/busyw_result.sv
module busyw_result #(
  parameter int CNT_W  = 17,
  parameter int OFFSET = 10001,
  parameter int RANGE  = 20000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               busy_fall,
  input  logic [CNT_W-1:0]   count,
  input  logic               res_ready,
  output logic               res_valid,
  output logic [CNT_W-2:0]   res_value,
  output logic               res_ovr
);
  localparam int RES_W = CNT_W - 1;
  localparam logic [RES_W-1:0] OFF_L = RES_W'(OFFSET);
  localparam logic [RES_W-1:0] RNG_L = RES_W'(RANGE);

  logic [RES_W-1:0] halved, reading;

  always_comb begin
    halved  = count[CNT_W-1:1];
    reading = (halved < OFF_L) ? '0 : halved - OFF_L;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_value <= '0;
      res_ovr   <= 1'b0;
    end else if (busy_fall) begin
      res_valid <= 1'b1;
      res_value <= reading;
      res_ovr   <= (reading > RNG_L);
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready && !busy_fall) |=>
      (res_valid && $stable(res_value) && $stable(res_ovr))); // R8
  AST_OVR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_ovr == (res_value > RNG_L))); // R7
endmodule

// File: rtl/busyw_reader.sv
module busyw_reader
  import busyw_pkg::*;
#(
  parameter int DIV    = DIV_DEF,
  parameter int CNT_W  = CNT_W_DEF,
  parameter int OFFSET = OFFSET_DEF,
  parameter int RANGE  = RANGE_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic             busy_in,
  output logic             conv_clk,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [CNT_W-2:0] res_value,
  output logic             res_ovr
);
  logic             cnt_tick, busy_s, busy_fall;
  logic [CNT_W-1:0] count;

  busyw_divider #(.DIV(DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
    .conv_clk(conv_clk), .cnt_tick(cnt_tick)
  );

  busyw_sync u_sync (
    .clk(clk), .rst_n(rst_n), .busy_in(busy_in),
    .busy_s(busy_s), .busy_fall(busy_fall)
  );

  busyw_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .busy_s(busy_s), .busy_fall(busy_fall),
    .cnt_tick(cnt_tick), .count(count)
  );

  busyw_result #(.CNT_W(CNT_W), .OFFSET(OFFSET), .RANGE(RANGE)) u_res (
    .clk(clk), .rst_n(rst_n), .busy_fall(busy_fall), .count(count),
    .res_ready(res_ready), .res_valid(res_valid),
    .res_value(res_value), .res_ovr(res_ovr)
  );

  AST_VALID_FROM_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(busy_fall)); // R4
endmodule

// File: tb/tb_busyw_reader.sv
`timescale 1ns/1ps
module tb_busyw_reader;
  localparam int DIV = 4, CNT_W = 10, OFFSET = 101, RANGE = 200;
  localparam int RES_W = CNT_W - 1;

  logic clk = 0, rst_n = 0, ref_tick = 0, busy_in = 0, res_ready = 1;
  logic conv_clk, res_valid, res_ovr;
  logic [RES_W-1:0] res_value;

  int checks = 0, fails = 0;

  busyw_reader #(.DIV(DIV), .CNT_W(CNT_W), .OFFSET(OFFSET), .RANGE(RANGE)) dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .busy_in(busy_in),
    .conv_clk(conv_clk), .res_valid(res_valid), .res_ready(res_ready),
    .res_value(res_value), .res_ovr(res_ovr)
  );

  always #5 clk = ~clk;

  // behavioural reference model
  bit m_b[$];
  int m_ph = 0, m_cnt = 0, m_res = 0;
  bit m_conv = 0, m_valid = 0, m_ovr = 0, m_last = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_b = {0, 0, 0}; m_ph = 0; m_cnt = 0; m_res = 0;
      m_conv = 0; m_valid = 0; m_ovr = 0;
    end else begin
      bit synced, fall, tick;
      int h;
      synced = m_b[1];
      fall   = m_b[2] && !m_b[1];
      tick   = ref_tick && ((m_ph % (DIV/2)) == (DIV/2 - 1));
      if (fall) begin
        h = m_cnt / 2;
        m_res = (h < OFFSET) ? 0 : h - OFFSET;
        m_ovr = (m_res > RANGE);
        m_valid = 1;
        m_cnt = 0;
      end else begin
        if (res_ready) m_valid = 0;
        if (synced && tick && m_cnt < (1 << CNT_W) - 1) m_cnt++;
      end
      if (ref_tick) begin
        m_ph = (m_ph + 1) % DIV;
        m_conv = (m_ph >= DIV/2);
      end
      void'(m_b.pop_back());
      m_b.push_front(busy_in);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    check(conv_clk == m_conv, rst_n ? "R1 conv_clk" : "R10 conv_clk", conv_clk, m_conv);
    check(res_valid == m_valid, rst_n ? "R4/R8 valid" : "R10 valid", res_valid, m_valid);
    check(res_value == RES_W'(m_res), rst_n ? "R5/R6 value" : "R10 value", res_value, m_res);
    check(res_ovr == m_ovr, rst_n ? "R7 ovr" : "R10 ovr", res_ovr, m_ovr);
  end

  task automatic measure(input int w, output int val, output bit ovr);
    busy_in = 1;
    repeat (w) @(negedge clk);
    #1 busy_in = 0;
    repeat (3) @(negedge clk);
    val = res_value; ovr = res_ovr;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int v, hi, rises;
    bit o, prev;
    repeat (3) @(negedge clk);
    check(res_valid == 0 && res_ovr == 0 && res_value == 0 && conv_clk == 0, "R10 reset", res_valid, 0);
    #1 rst_n = 1; ref_tick = 1;

    // R1: divide by DIV, half duty
    hi = 0; rises = 0; prev = conv_clk;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (conv_clk) hi++;
      if (conv_clk && !prev) rises++;
      prev = conv_clk;
    end
    check(hi == 20, "R1 high cycles", hi, 20);
    check(rises == 10, "R1 rising edges", rises, 10);

    // R4: latency of two sync flops plus result register
    #1 busy_in = 1;
    repeat (40) @(negedge clk);
    #1 busy_in = 0;
    @(negedge clk); check(!res_valid, "R4 edge k", res_valid, 0);
    @(negedge clk); check(!res_valid, "R4 edge k+1", res_valid, 0);
    @(negedge clk); check(res_valid, "R4 edge k+2", res_valid, 1);
    repeat (4) @(negedge clk);

    #1; measure(100, v, o);
    check(v == 0 && !o, "R6 clamp", v, 0);
    #1; measure(1004, v, o);
    check(v == 150 && !o, "R5 reading", v, 150);
    repeat (800) @(negedge clk);
    #1; measure(1004, v, o);
    check(v == 150, "R9 fresh start", v, 150);
    #1; measure(1404, v, o);
    check(v == 250 && o, "R7 overrange", v, 250);
    #1; measure(2200, v, o);
    check(v == 410 && o, "R3 saturation", v, 410);

    // R2: counts only on reference ticks while busy
    #1 ref_tick = 0; busy_in = 1;
    repeat (500) @(negedge clk);
    #1 ref_tick = 1;
    repeat (1004) @(negedge clk);
    #1 ref_tick = 0;
    repeat (500) @(negedge clk);
    #1 busy_in = 0;
    repeat (3) @(negedge clk);
    check(res_value == 150, "R2 gated ticks", res_value, 150);
    #1 ref_tick = 1;

    // R8: hold while not ready, then overwrite by next measurement
    res_ready = 0;
    #1; measure(1404, v, o);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check(res_valid && res_value == 250 && res_ovr, "R8 hold", res_value, 250);
    end
    #1; measure(1004, v, o);
    check(v == 150 && res_valid, "R8 overwrite", v, 150);
    #1 res_ready = 1;
    repeat (2) @(negedge clk);
    check(!res_valid, "R8 accept", res_valid, 0);

    // irregular reference ticks against the model
    for (int n = 0; n < 3; n++) begin
      #1 busy_in = 1;
      for (int i = 0; i < 900 + 200 * n; i++) begin
        @(negedge clk);
        #1 ref_tick = ($urandom_range(0, 3) != 0);
        res_ready = ($urandom_range(0, 1) != 0);
      end
      busy_in = 0; res_ready = 1;
      repeat (20) @(negedge clk);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule